// File: doc/BRIEF.md
# Floating Add/Subtract Operand Aligner

This block is the front end of a single-precision floating adder and subtractor for 36-bit words. Each word has three fields. Bit 35 is the sign. Bits 34:27 hold an excess-128 exponent. Bits 26:0 hold the fraction. A negative value is stored as the two's complement of the whole word. The block takes two operands and an add/subtract select, and works out which operand has the larger exponent. It then shifts the other operand's fraction right into a 72-bit field, adds the two signed fractions, and registers the raw sum and a provisional exponent for a normalizer that follows it.

The caller drives both operands and the select, and pulses `start` for one cycle. On the next cycle `valid_o` pulses for one cycle, and `sum_o` and `exp_o` carry the result. The result registers keep their value until the next `start`. Normalization and rounding are left to the next stage.

Top module: `fp_add_align`

## Requirements
- R1: When `sub` is 1, `op_b` is negated as a whole 36-bit two's-complement word before exponents are read, so the result is `op_a - op_b` through the same adder; subtracting a positive word with a nonzero fraction from itself yields a zero sum.
- R2: Exponents are bits 34:27. For a word with bit 35 set, the exponent is the ones' complement of those bits. `exp_o` equals the larger of the two exponents plus one, as a 9-bit value.
- R3: The signed fraction of each operand is bits 26:0 sign-extended from bit 35. It is placed at bits 71:36 of a 72-bit value. The operand with the larger exponent is not shifted, and on equal exponents `op_a` counts as larger. Both values are shifted arithmetically right by two before the add, and `sum_o` is their 72-bit two's-complement sum.
- R4: The smaller operand is shifted arithmetically right by the exponent difference. When the difference exceeds 36, bits 71:36 of the shifted value hold only copies of its sign.
- R5: When the exponent difference is 72 or more, the smaller operand contributes only its sign fill: zero if it is positive, and all ones if it is negative.
- R6: `valid_o` is 1 for exactly the cycle after each cycle in which `start` is 1, and 0 otherwise.
- R7: When both `op_a` and the effective `op_b` are all zero, `sum_o` and `exp_o` are both zero and `valid_o` still pulses.
- R8: While `rst_n` is 0, `valid_o`, `sum_o` and `exp_o` are 0.
- R9: In a cycle without `start`, `sum_o` and `exp_o` keep their previous values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to align and add the operands |
| sub | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| op_a | input | 36 | First operand word |
| op_b | input | 36 | Second operand word |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| sum_o | output | 72 | Raw signed sum of the aligned fractions, scaled by one quarter |
| exp_o | output | 9 | Provisional exponent: larger exponent plus one |

## Verification
The bench targets exponent differences just below 36, between 36 and 72, and past 72. A shifter that wraps the shift count or zero-fills would leave stray bits in the sum, or drop the -1 fill that a far negative operand must add. Negative operands check exponent recovery: reading the stored exponent bits directly would pick the wrong larger operand and give an exponent far off. Self-subtraction and operand swap under subtraction check that the subtrahend is negated as a whole word, not by flipping its sign bit. Operand changes between requests check that the result registers do not follow the inputs.

// File: rtl/fp_add_align.sv
module fp_add_align #(
  parameter int W  = 36,
  parameter int EW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sub,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic            valid_o,
  output logic [2*W-1:0]  sum_o,
  output logic [EW:0]     exp_o
);
  localparam int FW = W - 1 - EW;
  localparam int DW = 2 * W;

  logic [W-1:0]  b_eff;
  logic [EW-1:0] ea, eb, e_big, diff;
  logic          a_big, both_zero;
  logic [W-1:0]  w_big, w_small;
  logic signed [W-1:0]  f_big, f_small;
  logic signed [DW-1:0] x_big, x_small, sum_n;
  logic [EW:0]   exp_n;

  assign b_eff = sub ? -op_b : op_b;

  assign ea = op_a[W-1]  ? ~op_a[W-2:FW]  : op_a[W-2:FW];
  assign eb = b_eff[W-1] ? ~b_eff[W-2:FW] : b_eff[W-2:FW];

  assign a_big   = ea >= eb;
  assign e_big   = a_big ? ea : eb;
  assign diff    = a_big ? ea - eb : eb - ea;
  assign w_big   = a_big ? op_a : b_eff;
  assign w_small = a_big ? b_eff : op_a;

  assign f_big   = $signed({{(EW+1){w_big[W-1]}},   w_big[FW-1:0]});
  assign f_small = $signed({{(EW+1){w_small[W-1]}}, w_small[FW-1:0]});

  assign x_big   = $signed({f_big, {W{1'b0}}});
  assign x_small = $signed({f_small, {W{1'b0}}}) >>> diff;

  assign sum_n     = (x_big >>> 2) + (x_small >>> 2);
  assign exp_n     = (EW+1)'(e_big) + (EW+1)'(1);
  assign both_zero = (op_a == '0) && (b_eff == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      exp_o   <= '0;
    end else begin
      valid_o <= start;
      if (start) begin
        sum_o <= both_zero ? '0 : sum_n;
        exp_o <= both_zero ? '0 : exp_n;
      end
    end
  end
endmodule

// File: rtl/fp_add_align_chk.sv
module fp_add_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        sub,
  input logic [35:0] op_a,
  input logic [35:0] op_b,
  input logic        valid_o,
  input logic [71:0] sum_o,
  input logic [8:0]  exp_o
);
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid_o); // R6

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid_o); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(sum_o) && $stable(exp_o))); // R9

  AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_a == 36'd0 && op_b == 36'd0) |=> (sum_o == 72'd0 && exp_o == 9'd0)); // R7

  AST_SELF_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sub && op_a == op_b && !op_a[35] && op_a[26:0] != 27'd0) |=> (sum_o == 72'd0)); // R1

  AST_FAR_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sub && !op_a[35] && !op_b[35] &&
     {1'b0, op_a[34:27]} >= {1'b0, op_b[34:27]} + 9'd72) |=> (sum_o[33:0] == 34'd0)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!valid_o && sum_o == 72'd0 && exp_o == 9'd0)); // R8
endmodule

bind fp_add_align fp_add_align_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
  .op_a(op_a), .op_b(op_b), .valid_o(valid_o), .sum_o(sum_o), .exp_o(exp_o)
);

// File: tb/fp_add_align_tb.sv
`timescale 1ns/1ps
module fp_add_align_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sub = 1'b0;
  logic [35:0] op_a = '0;
  logic [35:0] op_b = '0;
  logic valid_o;
  logic [71:0] sum_o;
  logic [8:0] exp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_add_align dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
    .op_a(op_a), .op_b(op_b), .valid_o(valid_o), .sum_o(sum_o), .exp_o(exp_o)
  );

  function automatic logic [35:0] mk(input bit neg, input int e, input int frac);
    logic [35:0] w;
    w = {1'b0, 8'(e), 27'(frac)};
    return neg ? (~w + 36'd1) : w;
  endfunction

  function automatic int expo(input logic [35:0] w);
    return w[35] ? 255 - int'(w[34:27]) : int'(w[34:27]);
  endfunction

  function automatic logic signed [79:0] fracv(input logic [35:0] w);
    longint f;
    logic signed [79:0] v;
    f = longint'(w[26:0]) - (w[35] ? longint'(134217728) : longint'(0));
    v = f;
    return v <<< 36;
  endfunction

  logic        m_valid = 0;
  logic [71:0] m_sum = '0;
  logic [8:0]  m_exp = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0; m_sum <= '0; m_exp <= '0;
    end else begin
      m_valid <= start;
      if (start) begin
        logic [35:0] bb;
        int ea, eb, d;
        logic signed [79:0] vb, vs;
        bb = sub ? (~op_b + 36'd1) : op_b;
        if (op_a == 0 && bb == 0) begin
          m_sum <= '0; m_exp <= '0;
        end else begin
          ea = expo(op_a); eb = expo(bb);
          if (ea >= eb) begin vb = fracv(op_a); vs = fracv(bb); d = ea - eb; m_exp <= 9'(ea + 1); end
          else begin vb = fracv(bb); vs = fracv(op_a); d = eb - ea; m_exp <= 9'(eb + 1); end
          vs = vs >>> (d + 2);
          vb = vb >>> 2;
          m_sum <= 72'(vb + vs);
        end
      end
    end
  end

  always @(negedge clk) if (!done) begin
    checks += 3;
    if (valid_o !== m_valid) begin errors++; $display("FAIL R6 valid actual=%0b expected=%0b", valid_o, m_valid); end
    if (sum_o !== m_sum) begin errors++; $display("FAIL R3 sum actual=%h expected=%h", sum_o, m_sum); end
    if (exp_o !== m_exp) begin errors++; $display("FAIL R2 exp actual=%0d expected=%0d", exp_o, m_exp); end
  end

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic run(input logic [35:0] a, input logic [35:0] b, input logic s);
    @(negedge clk); op_a = a; op_b = b; sub = s; start = 1;
    @(negedge clk); start = 0;
  endtask

  localparam logic [71:0] ONE = 72'd1;

  initial begin
    #200000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset valid", 72'(valid_o), 72'd0);
    chk("R8 reset sum", sum_o, 72'd0);
    chk("R8 reset exp", 72'(exp_o), 72'd0);
    rst_n = 1;

    run(mk(0,130,1<<26), mk(0,130,1<<26), 0);
    chk("R3 equal add sum", sum_o, ONE << 61);
    chk("R2 equal add exp", 72'(exp_o), 72'd131);
    chk("R6 valid pulse", 72'(valid_o), 72'd1);
    @(negedge clk);
    chk("R6 valid drop", 72'(valid_o), 72'd0);

    run(mk(0,180,1<<26), mk(0,130,1<<26), 0);
    chk("R4 diff 50 sum", sum_o, (ONE << 60) + (ONE << 10));
    chk("R4 diff 50 exp", 72'(exp_o), 72'd181);

    run(mk(0,210,1<<26), mk(1,130,1<<26), 0);
    chk("R5 far negative sum", sum_o, (ONE << 60) - ONE);
    chk("R5 far negative exp", 72'(exp_o), 72'd211);

    run(mk(0,130,1<<26), mk(0,130,1<<26), 1);
    chk("R1 self subtract", sum_o, 72'd0);

    run(mk(0,131,1<<26), mk(0,130,1<<26), 1);
    chk("R1 subtract sum", sum_o, ONE << 59);
    chk("R1 subtract exp", 72'(exp_o), 72'd132);

    run(mk(1,140,1<<26), mk(0,130,1<<26), 0);
    chk("R2 negative larger sum", sum_o, (ONE << 50) - (ONE << 60));
    chk("R2 negative larger exp", 72'(exp_o), 72'd141);

    run(36'd0, 36'd0, 0);
    chk("R7 zero sum", sum_o, 72'd0);
    chk("R7 zero exp", 72'(exp_o), 72'd0);
    chk("R7 zero valid", 72'(valid_o), 72'd1);

    run(mk(0,150,1<<26), mk(0,100,1<<26), 0);
    @(negedge clk); op_a = mk(1,20,5); op_b = mk(0,250,7); sub = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 hold sum", sum_o, (ONE << 60) + (ONE << 10));
    chk("R9 hold exp", 72'(exp_o), 72'd151);

    for (int i = 0; i < 400; i++) begin
      logic [35:0] ra, rb;
      ra = {$urandom, $urandom} % (64'd1 << 36);
      rb = {$urandom, $urandom} % (64'd1 << 36);
      if (i % 3 == 0) rb = mk($urandom % 2, int'(ra[34:27]) - int'($urandom % 90), $urandom % (1 << 27));
      run(ra, rb, 1'($urandom % 2));
      if (i % 5 == 0) @(negedge clk);
    end
    repeat (2) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule